// File: doc/BRIEF.md
# Accumulator Shift and Result Latch Stage

This stage sits at the output of a signal-processing datapath that executes one program step at a time. On every accepted step it takes the accumulator value that the previous step produced, passes it through one of four shift modes (clamp, double and clamp, double, or pass-through) and registers the result. In the same step it can store that result into a 128-entry scratch RAM, reload a fractional multiplier-operand register, reload an address-offset register and write an effect-output register.

The accumulator is one step late on purpose. The stage keeps the accumulator value that came with the last accepted step. The shift of the current step works on that kept value, and the current step's accumulator is kept for the next step. This models the one-step delay at the output of the multiply-add. Every result is registered. The shifted value therefore stays steady for the whole cycle after the step, so the scratch write and any external memory write made from it see the same word.

Steps arrive on a valid-only interface: `step_valid` marks an accepted step. The stage never stalls, so it has no ready pin and the sender must not expect back-pressure. A cycle with `step_valid` low is a bubble. It changes no state and issues no write.

Top module: `shift_latch_unit`

## Requirements
- R1: After reset, every output is zero and both write strobes (`tmp_we`, `efx_we`) are low.
- R2: The shifted result of a step comes from the `acc_in` presented with the previous accepted step, not from the current one, and bubble cycles in between do not disturb it. Results appear on the outputs in the cycle after the step.
- R3: `shift_mode` 0 sign-extends the kept accumulator and clamps it to -0x800000..0x7FFFFF.
- R4: `shift_mode` 1 doubles the kept accumulator and clamps the result to -0x800000..0x7FFFFF.
- R5: `shift_mode` 2 doubles the kept accumulator with no clamp, giving a 27-bit two's-complement value.
- R6: `shift_mode` 3 passes the kept accumulator through, sign-extended to 27 bits.
- R7: A step with `tmp_wr` set pulses `tmp_we` for one cycle. `tmp_addr` is (`tmp_ofs` + `ring_ct`) mod 128 and `tmp_wdata` is the shifted result.
- R8: A step with `frc_ld` set loads `frc`. In mode 3 `frc` gets bits [11:0] of the shifted result, zero-extended. In the other modes it gets the shifted result arithmetically shifted right by 11, keeping the low 13 bits. Otherwise `frc` holds its value.
- R9: A step with `adr_ld` set loads `adrs`. In mode 3 `adrs` gets the shifted result arithmetically shifted right by 12. In the other modes it gets `in_val` arithmetically shifted right by 16. Both are sign-extended or truncated to 16 bits. Otherwise `adrs` holds its value.
- R10: A step with `efx_wr` set pulses `efx_we` for one cycle. `efx_idx` is the step's `efx_sel` and `efx_wdata` is the low 16 bits of the shifted result arithmetically shifted right by 8.
- R11: A cycle with `step_valid` low leaves every register unchanged and pulses no write strobe, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_valid | input | 1 | Accepted step in this cycle |
| acc_in | input | 26 | Accumulator produced by this step (used on the next step) |
| shift_mode | input | 2 | Shift mode 0..3 |
| in_val | input | 24 | Step input value for the address register |
| tmp_wr | input | 1 | Store the shifted result to scratch RAM |
| tmp_ofs | input | 7 | Scratch offset |
| ring_ct | input | 7 | Ring-buffer step counter |
| frc_ld | input | 1 | Load the fractional register |
| adr_ld | input | 1 | Load the address register |
| efx_wr | input | 1 | Write an effect-output register |
| efx_sel | input | 4 | Effect-output register index |
| shifted | output | 27 | Registered shifted result |
| tmp_we | output | 1 | Scratch write strobe |
| tmp_addr | output | 7 | Scratch write address |
| tmp_wdata | output | 27 | Scratch write data |
| frc | output | 13 | Fractional operand register |
| adrs | output | 16 | Address offset register |
| efx_we | output | 1 | Effect-output write strobe |
| efx_idx | output | 4 | Effect-output write index |
| efx_wdata | output | 16 | Effect-output write data |

## Verification
The hardest case to reach from the ports is the step delay. A mode only shows what it does with an accumulator that was supplied one step earlier. A fault that uses the current `acc_in` still looks right whenever the two values happen to match. For each table entry the bench therefore loads the accumulator on one step with every write disabled, inserts bubbles carrying misleading control inputs, and then applies the mode on a second step whose own `acc_in` is zero. The table covers the exact clamp edges, values just past them, and the extremes of the 26-bit range.

// File: rtl/shl_pkg.sv
package shl_pkg;
  typedef enum logic [1:0] {
    SHM_CLAMP     = 2'd0,
    SHM_DBL_CLAMP = 2'd1,
    SHM_DBL       = 2'd2,
    SHM_PASS      = 2'd3
  } shift_mode_e;
endpackage

// File: rtl/shl_shifter.sv
module shl_shifter #(
  parameter int ACC_W = 26,
  parameter int SAT_W = 24,
  localparam int SH_W = ACC_W + 1
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [1:0]       mode,
  output logic [SH_W-1:0]  result
);
  import shl_pkg::*;
  localparam logic signed [SH_W-1:0] MAXV = SH_W'((64'sd1 <<< (SAT_W-1)) - 64'sd1);
  localparam logic signed [SH_W-1:0] MINV = -SH_W'(64'sd1 <<< (SAT_W-1));

  logic signed [SH_W-1:0] ext, dbl, pick;

  always_comb begin
    ext  = SH_W'($signed(acc));
    dbl  = ext <<< 1;
    pick = (mode == SHM_DBL_CLAMP) ? dbl : ext;
    unique case (shift_mode_e'(mode))
      SHM_CLAMP, SHM_DBL_CLAMP: begin
        if (pick > MAXV)      result = MAXV;
        else if (pick < MINV) result = MINV;
        else                  result = pick;
      end
      SHM_DBL:  result = dbl;
      default:  result = ext;
    endcase
  end
endmodule

// File: rtl/shl_extract.sv
module shl_extract #(
  parameter int SH_W   = 27,
  parameter int IN_W   = 24,
  parameter int FRC_W  = 13,
  parameter int ADRS_W = 16,
  parameter int EF_W   = 16
) (
  input  logic [SH_W-1:0]   sh,
  input  logic [1:0]        mode,
  input  logic [IN_W-1:0]   in_val,
  output logic [FRC_W-1:0]  frc_val,
  output logic [ADRS_W-1:0] adrs_val,
  output logic [EF_W-1:0]   ef_val
);
  import shl_pkg::*;
  logic signed [63:0] sh_w, in_w, sar11, sar12, sar16, sar8;

  always_comb begin
    sh_w  = 64'($signed(sh));
    in_w  = 64'($signed(in_val));
    sar11 = sh_w >>> 11;
    sar12 = sh_w >>> 12;
    sar16 = in_w >>> 16;
    sar8  = sh_w >>> 8;
    if (mode == SHM_PASS) begin
      frc_val  = FRC_W'(sh_w[11:0]);
      adrs_val = sar12[ADRS_W-1:0];
    end else begin
      frc_val  = sar11[FRC_W-1:0];
      adrs_val = sar16[ADRS_W-1:0];
    end
    ef_val = sar8[EF_W-1:0];
  end
endmodule

// File: rtl/shl_ring_index.sv
module shl_ring_index #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] ofs,
  input  logic [AW-1:0] ct,
  output logic [AW-1:0] idx
);
  always_comb idx = ofs + ct;
endmodule

// File: rtl/shift_latch_unit.sv
module shift_latch_unit #(
  parameter int ACC_W  = 26,
  parameter int SAT_W  = 24,
  parameter int IN_W   = 24,
  parameter int TMP_AW = 7,
  parameter int EFX_AW = 4,
  parameter int FRC_W  = 13,
  parameter int ADRS_W = 16,
  parameter int EF_W   = 16,
  localparam int SH_W  = ACC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_valid,
  input  logic [ACC_W-1:0]  acc_in,
  input  logic [1:0]        shift_mode,
  input  logic [IN_W-1:0]   in_val,
  input  logic              tmp_wr,
  input  logic [TMP_AW-1:0] tmp_ofs,
  input  logic [TMP_AW-1:0] ring_ct,
  input  logic              frc_ld,
  input  logic              adr_ld,
  input  logic              efx_wr,
  input  logic [EFX_AW-1:0] efx_sel,
  output logic [SH_W-1:0]   shifted,
  output logic              tmp_we,
  output logic [TMP_AW-1:0] tmp_addr,
  output logic [SH_W-1:0]   tmp_wdata,
  output logic [FRC_W-1:0]  frc,
  output logic [ADRS_W-1:0] adrs,
  output logic              efx_we,
  output logic [EFX_AW-1:0] efx_idx,
  output logic [EF_W-1:0]   efx_wdata
);
  logic [ACC_W-1:0]  acc_q;
  logic [SH_W-1:0]   sh_nxt, sh_q;
  logic [FRC_W-1:0]  frc_nxt, frc_q;
  logic [ADRS_W-1:0] adrs_nxt, adrs_q;
  logic [EF_W-1:0]   ef_nxt, ef_q;
  logic [TMP_AW-1:0] idx_nxt, addr_q;
  logic [EFX_AW-1:0] efi_q;
  logic              twe_q, ewe_q;

  shl_shifter #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_shift (
    .acc(acc_q), .mode(shift_mode), .result(sh_nxt)
  );

  shl_extract #(.SH_W(SH_W), .IN_W(IN_W), .FRC_W(FRC_W),
                .ADRS_W(ADRS_W), .EF_W(EF_W)) u_ext (
    .sh(sh_nxt), .mode(shift_mode), .in_val(in_val),
    .frc_val(frc_nxt), .adrs_val(adrs_nxt), .ef_val(ef_nxt)
  );

  shl_ring_index #(.AW(TMP_AW)) u_idx (
    .ofs(tmp_ofs), .ct(ring_ct), .idx(idx_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      sh_q   <= '0;
      frc_q  <= '0;
      adrs_q <= '0;
      ef_q   <= '0;
      addr_q <= '0;
      efi_q  <= '0;
      twe_q  <= 1'b0;
      ewe_q  <= 1'b0;
    end else begin
      twe_q <= step_valid && tmp_wr;
      ewe_q <= step_valid && efx_wr;
      if (step_valid) begin
        acc_q <= acc_in;
        sh_q  <= sh_nxt;
        if (tmp_wr) addr_q <= idx_nxt;
        if (frc_ld) frc_q  <= frc_nxt;
        if (adr_ld) adrs_q <= adrs_nxt;
        if (efx_wr) begin
          ef_q  <= ef_nxt;
          efi_q <= efx_sel;
        end
      end
    end
  end

  assign shifted   = sh_q;
  assign tmp_we    = twe_q;
  assign tmp_addr  = addr_q;
  assign tmp_wdata = sh_q;
  assign frc       = frc_q;
  assign adrs      = adrs_q;
  assign efx_we    = ewe_q;
  assign efx_idx   = efi_q;
  assign efx_wdata = ef_q;
endmodule

// File: rtl/shift_latch_unit_chk.sv
module shift_latch_unit_chk #(
  parameter int SH_W   = 27,
  parameter int SAT_W  = 24,
  parameter int FRC_W  = 13,
  parameter int ADRS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_valid,
  input logic [1:0]        shift_mode,
  input logic              tmp_wr,
  input logic              frc_ld,
  input logic              adr_ld,
  input logic              efx_wr,
  input logic [SH_W-1:0]   shifted,
  input logic              tmp_we,
  input logic [FRC_W-1:0]  frc,
  input logic [ADRS_W-1:0] adrs,
  input logic              efx_we
);
  localparam logic signed [SH_W-1:0] MAXV = SH_W'((64'sd1 <<< (SAT_W-1)) - 64'sd1);
  localparam logic signed [SH_W-1:0] MINV = -SH_W'(64'sd1 <<< (SAT_W-1));

  p_tmp_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmp_we |-> $past(step_valid && tmp_wr));
  p_efx_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    efx_we |-> $past(step_valid && efx_wr));
  p_frc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_valid && frc_ld) |=> $stable(frc));
  p_adrs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_valid && adr_ld) |=> $stable(adrs));
  p_clamp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && shift_mode[1] == 1'b0) |=>
      ($signed(shifted) <= MAXV && $signed(shifted) >= MINV));
  p_bubble_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |=> (!tmp_we && !efx_we && $stable(shifted)));
endmodule

bind shift_latch_unit shift_latch_unit_chk #(
  .SH_W(SH_W), .SAT_W(SAT_W), .FRC_W(FRC_W), .ADRS_W(ADRS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .shift_mode(shift_mode),
  .tmp_wr(tmp_wr), .frc_ld(frc_ld), .adr_ld(adr_ld), .efx_wr(efx_wr),
  .shifted(shifted), .tmp_we(tmp_we), .frc(frc), .adrs(adrs), .efx_we(efx_we)
);

// File: tb/tb_shift_latch_unit.sv
module tb_shift_latch_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_valid = 1'b0;
  logic [25:0] acc_in = '0;
  logic [1:0]  shift_mode = '0;
  logic [23:0] in_val = '0;
  logic tmp_wr = 1'b0, frc_ld = 1'b0, adr_ld = 1'b0, efx_wr = 1'b0;
  logic [6:0] tmp_ofs = '0, ring_ct = '0;
  logic [3:0] efx_sel = '0;
  logic [26:0] shifted, tmp_wdata;
  logic tmp_we, efx_we;
  logic [6:0] tmp_addr;
  logic [12:0] frc;
  logic [15:0] adrs, efx_wdata;
  logic [3:0] efx_idx;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  shift_latch_unit dut (.*);

  // {acc (26), mode (2), expected shifted (27)}
  localparam int NV = 14;
  localparam logic [54:0] VEC [NV] = '{
    {26'h0001234, 2'd0, 27'h0001234},
    {26'h07FFFFF, 2'd0, 27'h07FFFFF},
    {26'h0900000, 2'd0, 27'h07FFFFF},
    {26'h3800000, 2'd0, 27'h7800000},
    {26'h3700000, 2'd0, 27'h7800000},
    {26'h0300000, 2'd1, 27'h0600000},
    {26'h0500000, 2'd1, 27'h07FFFFF},
    {26'h3A00000, 2'd1, 27'h7800000},
    {26'h3FFFFFF, 2'd1, 27'h7FFFFFE},
    {26'h0500000, 2'd2, 27'h0A00000},
    {26'h3A00000, 2'd2, 27'h7400000},
    {26'h1FFFFFF, 2'd2, 27'h3FFFFFE},
    {26'h1FFFFFF, 2'd3, 27'h1FFFFFF},
    {26'h2000000, 2'd3, 27'h6000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [25:0] a, input logic [1:0] m, input logic [23:0] iv,
                      input logic tw, input logic fl, input logic al, input logic ew,
                      input logic [6:0] ofs, input logic [6:0] ct, input logic [3:0] es);
    @(negedge clk);
    step_valid = 1'b1; acc_in = a; shift_mode = m; in_val = iv;
    tmp_wr = tw; frc_ld = fl; adr_ld = al; efx_wr = ew;
    tmp_ofs = ofs; ring_ct = ct; efx_sel = es;
    @(negedge clk);
    step_valid = 1'b0; tmp_wr = 1'b0; frc_ld = 1'b0; adr_ld = 1'b0; efx_wr = 1'b0;
  endtask

  task automatic bubble_noise();
    @(negedge clk);
    acc_in = 26'h1555555; shift_mode = 2'd3;
    tmp_wr = 1'b1; frc_ld = 1'b1; adr_ld = 1'b1; efx_wr = 1'b1;
    @(negedge clk);
    tmp_wr = 1'b0; frc_ld = 1'b0; adr_ld = 1'b0; efx_wr = 1'b0;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [26:0] e_sh, p_sh, p_frc;
    logic [63:0] w;
    logic [15:0] e_adrs;
    logic [12:0] e_frc;
    logic [23:0] iv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 shifted", 32'(shifted), 0);
    chk("R1 strobes", {30'd0, tmp_we, efx_we}, 0);
    chk("R1 frc/adrs", {3'd0, frc, adrs}, 0);
    chk("R1 ef", {12'd0, efx_idx, efx_wdata}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      // load accumulator, no writes
      step(VEC[i][54:29], 2'd0, 24'h0, 0, 0, 0, 0, 7'd0, 7'd0, 4'd0);
      bubble_noise(); // R2/R11: bubbles must not disturb the kept value
      iv = 24'(24'h812345 + i * 24'h031111);
      step(26'h0, VEC[i][28:27], iv, 1, 1, 1, 1, 7'(i * 9), 7'd120, 4'(i));
      e_sh = VEC[i][26:0];
      case (VEC[i][28:27])
        2'd0: chk("R3 mode0 clamp", 32'(shifted), 32'(e_sh));
        2'd1: chk("R4 mode1 double clamp", 32'(shifted), 32'(e_sh));
        2'd2: chk("R5 mode2 double", 32'(shifted), 32'(e_sh));
        default: chk("R6 mode3 pass", 32'(shifted), 32'(e_sh));
      endcase
      chk("R7 tmp_we", 32'(tmp_we), 1);
      chk("R7 tmp_addr", 32'(tmp_addr), 32'((i * 9 + 120) % 128));
      chk("R7 tmp_wdata", 32'(tmp_wdata), 32'(e_sh));
      w = 64'($signed(e_sh));
      if (VEC[i][28:27] == 2'd3) begin
        e_frc  = {1'b0, e_sh[11:0]};
        e_adrs = 16'(w >>> 12);
      end else begin
        e_frc  = 13'(w >>> 11);
        e_adrs = 16'($signed(64'($signed(iv))) >>> 16);
      end
      chk("R8 frc", 32'(frc), 32'(e_frc));
      chk("R9 adrs", 32'(adrs), 32'(e_adrs));
      chk("R10 efx_we", 32'(efx_we), 1);
      chk("R10 efx_idx", 32'(efx_idx), i);
      chk("R10 efx_wdata", 32'(efx_wdata), 32'(16'(w >>> 8)));
      // R2: strobes are one-cycle pulses
      @(negedge clk);
      chk("R2 strobe pulse", {30'd0, tmp_we, efx_we}, 0);
    end

    // R2: the current step's accumulator is not the one shifted
    step(26'h0000100, 2'd3, 24'h0, 0, 0, 0, 0, 7'd0, 7'd0, 4'd0);
    step(26'h0000777, 2'd3, 24'h0, 0, 0, 0, 0, 7'd0, 7'd0, 4'd0);
    chk("R2 previous accumulator", 32'(shifted), 32'h100);

    // R8/R9: holds when not loaded
    p_frc = 27'(frc); e_adrs = adrs;
    step(26'h0, 2'd1, 24'h7F0000, 1, 0, 0, 0, 7'd5, 7'd5, 4'd0);
    chk("R8 frc hold", 32'(frc), 32'(p_frc));
    chk("R9 adrs hold", 32'(adrs), 32'(e_adrs));
    chk("R7 tmp_addr small", 32'(tmp_addr), 10);

    // R11: bubble with all enables changes nothing
    p_sh = shifted; p_frc = 27'(frc);
    @(negedge clk);
    acc_in = 26'h0ABCDEF; shift_mode = 2'd2; in_val = 24'h7FFFFF;
    tmp_wr = 1'b1; frc_ld = 1'b1; adr_ld = 1'b1; efx_wr = 1'b1;
    @(negedge clk);
    chk("R11 no tmp write", 32'(tmp_we), 0);
    chk("R11 no ef write", 32'(efx_we), 0);
    chk("R11 shifted kept", 32'(shifted), 32'(p_sh));
    chk("R11 frc kept", 32'(frc), 32'(p_frc));
    chk("R11 adrs kept", 32'(adrs), 32'(e_adrs));
    tmp_wr = 1'b0; frc_ld = 1'b0; adr_ld = 1'b0; efx_wr = 1'b0;

    // R1: reset again clears loaded state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset reload", {5'd0, shifted}, 0);
    chk("R1 reset regs", {3'd0, frc, adrs}, 0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule